// File: doc/BRIEF.md
# Push-Button Combination Lock

A sequence-checking lock driven by three human-operated push buttons: a "0" digit button, a "1" digit button and a clear button. Every raw button line is brought into the clock domain through a flip-flop chain. A rising-edge stage then turns it into a one-cycle pulse, so one press of any length counts as exactly one event.

A Moore state machine records how many leading digits of a fixed five-digit code the recent presses have matched. It raises the unlock output only once the whole code has been entered. When a digit is wrong, the machine does not always restart. It keeps the longest tail of the entered digits that is still a valid start of the code, so an overlapping attempt such as 0,1,0,1,0,1,1 still opens the lock.

The code and its length are parameters. The default code is 0,1,0,1,1, and the state is held in 3 bits.

Top module: `combo_lock_top`

## Requirements
- R1: With the default `CODE` = 5'b01011, where the MSB is the first digit to enter, entering 0,1,0,1,1 in that order raises `unlock_o`.
- R2: A press held high for many cycles enters exactly one digit, and a digit pulse inside the block lasts one cycle.
- R3: `unlock_o` is 1 only while the full code is matched. It is 0 in each of the other five match states (0 to 4 digits matched).
- R4: A press of the clear button returns the machine to the nothing-matched state from any state, and this clears `unlock_o`. Clear has priority over a digit pulse in the same cycle.
- R5: A wrong digit moves the machine to the longest suffix of the entered digits that is also a prefix of the code. In particular:
  - from nothing-matched, a 1 stays in nothing-matched;
  - "0" followed by 0 stays in "0";
  - "01" followed by 1 goes to nothing-matched;
  - "010" followed by 0 goes to "0";
  - "0101" followed by 0 goes to "010".
- R6: If both digit pulses occur in the same cycle, they are ignored and the state is held. In cycles with no pulse, the state also holds.
- R7: While `rst_ni` is low, the machine is forced to nothing-matched and `unlock_o` is 0.
- R8: From the full-match state, a 0 goes to "0" and a 1 goes to nothing-matched. Both clear `unlock_o`.
- R9: With `SYNC_STAGES` = 2, `unlock_o` changes on the third rising clock edge after the final digit button goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_btn_i | input | 1 | Raw clear button level |
| zero_btn_i | input | 1 | Raw "0" digit button level |
| one_btn_i | input | 1 | Raw "1" digit button level |
| unlock_o | output | 1 | High while the full code is matched |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and the five-digit code 0,1,0,1,1. It sweeps every digit sequence of length one to seven, each starting from a clear. A model in the bench computes the longest matching suffix of each sequence by direct string comparison. Seven digits is enough to enter every state, take every wrong-digit arc and leave the full-match state by both digits. Separate cases cover held buttons, simultaneous digit presses, clear priority, reset during unlock and the exact cycle of the unlock edge.

// File: rtl/combo_pkg.sv
package combo_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_ZERO  = 2'd1,
    EV_ONE   = 2'd2,
    EV_CLEAR = 2'd3
  } combo_ev_e;

  localparam int unsigned BTN_CLEAR = 0;
  localparam int unsigned BTN_ZERO  = 1;
  localparam int unsigned BTN_ONE   = 2;
  localparam int unsigned BTN_NUM   = 3;
endpackage

// File: rtl/combo_sync.sv
module combo_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= raw_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/combo_edge.sv
module combo_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= level_i;
  end

  assign pulse_o = level_i & ~prev_q;

  p_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/combo_seq.sv
module combo_seq #(
  parameter int unsigned CODE_LEN = 5,
  parameter logic [CODE_LEN-1:0] CODE = 5'b01011
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic zero_i,
  input  logic one_i,
  output logic unlock_o
);
  import combo_pkg::*;

  localparam int unsigned SW = $clog2(CODE_LEN + 1);
  localparam int unsigned NS = CODE_LEN + 1;

  // digit idx of code, first entered digit is MSB
  function automatic logic code_dig(input int unsigned idx);
    return CODE[CODE_LEN-1-idx];
  endfunction

  // longest suffix of (prefix[len] , dig) that is also a code prefix
  function automatic logic [SW-1:0] advance(input int unsigned len, input logic dig);
    int unsigned best;
    logic        ok;
    logic        ch;
    best = 0;
    for (int unsigned k = 1; k <= CODE_LEN; k++) begin
      if (k <= len + 1) begin
        ok = 1'b1;
        for (int unsigned j = 0; j < CODE_LEN; j++) begin
          if (j < k) begin
            if (len + 1 - k + j < len) ch = code_dig(len + 1 - k + j);
            else ch = dig;
            if (ch != code_dig(j)) ok = 1'b0;
          end
        end
        if (ok) best = k;
      end
    end
    return SW'(best);
  endfunction

  logic [SW-1:0] nxt_zero [NS];
  logic [SW-1:0] nxt_one  [NS];

  generate
    for (genvar s = 0; s < NS; s++) begin : g_tbl
      assign nxt_zero[s] = advance(s, 1'b0);
      assign nxt_one[s]  = advance(s, 1'b1);
    end
  endgenerate

  combo_ev_e     ev;
  logic [SW-1:0] state_q, state_d;

  always_comb begin
    if (clear_i)              ev = EV_CLEAR;
    else if (zero_i && !one_i) ev = EV_ZERO;
    else if (one_i && !zero_i) ev = EV_ONE;
    else                       ev = EV_NONE;
  end

  always_comb begin
    state_d = state_q;
    unique case (ev)
      EV_CLEAR: state_d = '0;
      EV_ZERO:  state_d = nxt_zero[state_q];
      EV_ONE:   state_d = nxt_one[state_q];
      default:  state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else state_q <= state_d;
  end

  assign unlock_o = (state_q == SW'(CODE_LEN));

  p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q <= SW'(CODE_LEN));
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (state_q == '0) && !unlock_o);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && (zero_i == one_i)) |=> $stable(state_q));
  p_grow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && (zero_i != one_i)) |=> state_q <= $past(state_q) + SW'(1));
  p_open_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && (zero_i != one_i) && (state_q == SW'(CODE_LEN-1)) && (one_i == CODE[0]))
    |=> unlock_o);
endmodule

// File: rtl/combo_lock_top.sv
module combo_lock_top #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CODE_LEN = 5,
  parameter logic [CODE_LEN-1:0] CODE = 5'b01011
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_btn_i,
  input  logic zero_btn_i,
  input  logic one_btn_i,
  output logic unlock_o
);
  import combo_pkg::*;

  logic [BTN_NUM-1:0] raw, lvl, pls;

  assign raw[BTN_CLEAR] = clear_btn_i;
  assign raw[BTN_ZERO]  = zero_btn_i;
  assign raw[BTN_ONE]   = one_btn_i;

  generate
    for (genvar b = 0; b < BTN_NUM; b++) begin : g_btn
      combo_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .raw_i (raw[b]),
        .sync_o(lvl[b])
      );
      combo_edge i_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .level_i(lvl[b]),
        .pulse_o(pls[b])
      );
    end
  endgenerate

  combo_seq #(.CODE_LEN(CODE_LEN), .CODE(CODE)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (pls[BTN_CLEAR]),
    .zero_i  (pls[BTN_ZERO]),
    .one_i   (pls[BTN_ONE]),
    .unlock_o(unlock_o)
  );
endmodule

// File: tb/test_combo_lock_top.sv
module test_combo_lock_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_b = 1'b0, zero_b = 1'b0, one_b = 1'b0;
  logic unlock;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int hist [0:63];
  int hlen = 0;
  int code [0:4] = '{0, 1, 0, 1, 1};

  always #5 clk = ~clk;

  combo_lock_top i_combo_lock_top (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .clear_btn_i(clr_b),
    .zero_btn_i (zero_b),
    .one_btn_i  (one_b),
    .unlock_o   (unlock)
  );

  function automatic int model_len();
    int best = 0;
    for (int k = 1; k <= 5; k++) begin
      bit ok = (k <= hlen);
      for (int j = 0; j < k && ok; j++)
        if (hist[hlen - k + j] != code[j]) ok = 0;
      if (ok) best = k;
    end
    return best;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: unlock actual=%b expected=%b (len=%0d)", req, act, exp, hlen);
    end
  endtask

  task automatic press(input int which, input int hold);
    @(negedge clk);
    if (which == 0) zero_b = 1'b1;
    else if (which == 1) one_b = 1'b1;
    else if (which == 2) clr_b = 1'b1;
    else begin zero_b = 1'b1; one_b = 1'b1; end
    repeat (hold) @(negedge clk);
    zero_b = 1'b0; one_b = 1'b0; clr_b = 1'b0;
    repeat (4) @(negedge clk);
    if (which <= 1) begin hist[hlen] = which; hlen++; end
    else if (which == 2) hlen = 0;
  endtask

  task automatic enter(input int d, input string req);
    press(d, 3);
    check(req, unlock, model_len() == 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7", unlock, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7", unlock, 1'b0);

    // R1 basic code
    enter(0, "R1"); enter(1, "R1"); enter(0, "R1"); enter(1, "R1"); enter(1, "R1");
    check("R1", unlock, 1'b1);
    // R8 exit by 1, then R5 overlap attempt
    enter(1, "R8"); check("R8", unlock, 1'b0);
    press(2, 3); check("R4", unlock, 1'b0);

    // R5 sweep: every sequence of length 1..7 from cleared state
    for (int len = 1; len <= 7; len++) begin
      for (int pat = 0; pat < (1 << len); pat++) begin
        press(2, 2);
        for (int i = 0; i < len; i++) enter((pat >> (len - 1 - i)) & 1, "R5");
      end
    end

    // R2 long hold counts once: 0,1,0,1 then held 1
    press(2, 2);
    enter(0, "R2"); press(1, 30); enter(0, "R2"); enter(1, "R2");
    check("R2", unlock, 1'b0);
    press(1, 40); check("R2", unlock, 1'b1);

    // R6 both digits together ignored: from full match, stays full
    press(3, 3); check("R6", unlock, 1'b1);
    // R8 exit by 0, then finish from "0"
    enter(0, "R8"); check("R8", unlock, 1'b0);
    enter(1, "R8"); enter(0, "R8"); enter(1, "R8"); enter(1, "R8");
    check("R8", unlock, 1'b1);
    // R6 at "0101": both pressed, then 1 still opens
    press(2, 2);
    enter(0, "R6"); enter(1, "R6"); enter(0, "R6"); enter(1, "R6");
    press(3, 3);
    enter(1, "R6"); check("R6", unlock, 1'b1);

    // R4 clear has priority over a simultaneous digit
    @(negedge clk); clr_b = 1'b1; zero_b = 1'b1;
    repeat (3) @(negedge clk); clr_b = 1'b0; zero_b = 1'b0;
    repeat (4) @(negedge clk); hlen = 0;
    check("R4", unlock, 1'b0);
    enter(1, "R4"); enter(0, "R4"); enter(1, "R4"); enter(1, "R4");
    check("R4", unlock, 1'b0);

    // R9 exact latency of the final digit
    press(2, 2);
    enter(0, "R9"); enter(1, "R9"); enter(0, "R9"); enter(1, "R9");
    @(negedge clk); one_b = 1'b1;
    @(negedge clk); check("R9", unlock, 1'b0);
    @(negedge clk); check("R9", unlock, 1'b0);
    @(negedge clk); check("R9", unlock, 1'b1);
    @(negedge clk); one_b = 1'b0;
    repeat (4) @(negedge clk);
    check("R3", unlock, 1'b1);

    // R7 async reset while unlocked
    @(negedge clk); rst_n = 1'b0;
    #2 check("R7", unlock, 1'b0);
    @(negedge clk); rst_n = 1'b1; hlen = 0;
    repeat (3) @(negedge clk);
    check("R7", unlock, 1'b0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule